// File: doc/BRIEF.md
# Interrupt-Enable and Control-Register Unit

This block keeps the processor's interrupt-enable state and a small set of control registers next to the pipeline. The enable state is three bits: a global enable that gates interrupts, a copy saved on exception entry, and a copy saved on breakpoint entry. Entering an exception or a breakpoint parks the global enable in its saved slot and clears it. The matching return puts the saved copy back into the global enable.

Besides the enable state it holds an exception vector base, a debug vector base, a free-running cycle counter and a read-only configuration word that reports how many breakpoint and watchpoint slots the core was built with. The pipeline reads and writes these through one index/strobe port. Each access is checked for legality against the kind of register addressed and the configured slot counts. An access that is not allowed raises a one-cycle fault flag, which the pipeline turns into an illegal-instruction trap. Read data and the fault flag are registered and appear one clock after the strobe.

Top module: `ctrl_csr_unit`

## Requirements
- R1: While reset is asserted, all three enable bits are 0, the exception base and debug base hold their reset parameters, the cycle counter holds CYC_INIT, and `rd_data` and `access_fault` are 0.
- R2: Index 0 is the enable register. Bit 0 is the global enable, bit 1 the exception-saved copy, bit 2 the breakpoint-saved copy, and the upper bits read as 0. A write loads bits 2..0 of `csr_wdata`. `irq_en` shows bit 0 from the clock after the write.
- R3: An `exc_entry` pulse copies the global enable into the exception-saved bit and clears the global enable.
- R4: A `brk_entry` pulse copies the global enable into the breakpoint-saved bit and clears the global enable.
- R5: An `exc_return` pulse sets the global enable equal to the exception-saved bit.
- R6: A `brk_return` pulse sets the global enable equal to the breakpoint-saved bit.
- R7: When several enable updates fall in one cycle, only one takes effect, in this order: exception entry, breakpoint entry, exception return, breakpoint return, register write.
- R8: Index 1 (exception base) and index 2 (debug base) are full-width read/write registers. A read returns the value held before any write in the same cycle.
- R9: The cycle counter (index 3) increases by one on every clock out of reset and wraps from all ones to zero.
- R10: Index 3 and index 4 are read-only. Index 4 reads NUM_BP in bits 3..0, NUM_WP in bits 7..4 and 0 above. A write to either leaves them unchanged and raises `access_fault`.
- R11: The cache-control registers (indices 5, 6), the breakpoint slots (8..11) and the watchpoint slots (12..15) are write-only. A read of one of them raises `access_fault` and leaves `rd_data` unchanged. A write to index 5 or 6 is accepted without a fault.
- R12: A write to breakpoint slot n (index 8+n) or watchpoint slot n (index 12+n) raises `access_fault` only when n is at or above NUM_BP or NUM_WP respectively.
- R13: Indices 7 and 16..31 are unknown. A read of one of them sets `rd_data` to 0 and raises `access_fault`. A write to one of them raises `access_fault` and changes nothing.
- R14: `rd_data` and `access_fault` update on the clock edge that samples the strobe. `access_fault` is high for exactly the cycles that follow a faulting access, and a cycle with no strobe leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_idx | input | 5 | Register index |
| csr_wdata | input | DATA_W | Write data |
| exc_entry | input | 1 | Exception taken pulse |
| brk_entry | input | 1 | Breakpoint taken pulse |
| exc_return | input | 1 | Return-from-exception pulse |
| brk_return | input | 1 | Return-from-breakpoint pulse |
| rd_data | output | DATA_W | Registered read data |
| irq_en | output | 1 | Current global interrupt enable |
| access_fault | output | 1 | One-cycle illegal-access flag |

## Verification
All results are due one clock after their stimulus. This applies to read data, the fault flag and the enable update. The counter advances at every edge, and a read captures its value from before that edge. The bench changes inputs on the falling edge. Its reference model advances at the same rising edge the design samples, and it compares all three outputs on the next falling edge, so each expectation is checked exactly one register stage after the inputs that caused it.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IX_STATUS = 5'd0;
  localparam logic [IDX_W-1:0] IX_EBASE  = 5'd1;
  localparam logic [IDX_W-1:0] IX_DBASE  = 5'd2;
  localparam logic [IDX_W-1:0] IX_CYCLES = 5'd3;
  localparam logic [IDX_W-1:0] IX_CONFIG = 5'd4;
  localparam logic [IDX_W-1:0] IX_ICACHE = 5'd5;
  localparam logic [IDX_W-1:0] IX_DCACHE = 5'd6;

  localparam int SLOT_MAX = 4;

  typedef enum logic [3:0] {
    K_STATUS, K_EBASE, K_DBASE, K_CYCLES, K_CONFIG,
    K_CACHE, K_BRKPT, K_WATCH, K_NONE
  } csr_kind_e;

  // bit 2 = breakpoint-saved, bit 1 = exception-saved, bit 0 = global
  typedef struct packed {
    logic bie;
    logic eie;
    logic ie;
  } ena_t;

  function automatic csr_kind_e kind_of(input logic [IDX_W-1:0] idx);
    csr_kind_e k;
    case (idx)
      IX_STATUS: k = K_STATUS;
      IX_EBASE:  k = K_EBASE;
      IX_DBASE:  k = K_DBASE;
      IX_CYCLES: k = K_CYCLES;
      IX_CONFIG: k = K_CONFIG;
      IX_ICACHE, IX_DCACHE: k = K_CACHE;
      5'd8, 5'd9, 5'd10, 5'd11:  k = K_BRKPT;
      5'd12, 5'd13, 5'd14, 5'd15: k = K_WATCH;
      default: k = K_NONE;
    endcase
    return k;
  endfunction

  function automatic logic [2:0] slot_of(input logic [IDX_W-1:0] idx);
    return {1'b0, idx[1:0]};
  endfunction

  function automatic ena_t next_enable(input ena_t cur, input logic exc,
                                       input logic brk, input logic eret,
                                       input logic bret, input logic wr,
                                       input logic [2:0] wbits);
    ena_t n;
    n = cur;
    if (exc) begin
      n.eie = cur.ie;
      n.ie  = 1'b0;
    end else if (brk) begin
      n.bie = cur.ie;
      n.ie  = 1'b0;
    end else if (eret) begin
      n.ie = cur.eie;
    end else if (bret) begin
      n.ie = cur.bie;
    end else if (wr) begin
      n = ena_t'(wbits);
    end
    return n;
  endfunction

endpackage

// File: rtl/csr_access_decode.sv
module csr_access_decode
  import csr_unit_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4
) (
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  output csr_kind_e        kind,
  output logic             rd_take,
  output logic             rd_clear,
  output logic             wr_status,
  output logic             wr_ebase,
  output logic             wr_dbase,
  output logic             fault
);

  localparam logic [2:0] BP_LIM = 3'(NUM_BP);
  localparam logic [2:0] WP_LIM = 3'(NUM_WP);

  logic rd_fault;
  logic wr_fault;
  logic slot_bad;

  assign kind = kind_of(idx);

  always_comb begin
    slot_bad = 1'b0;
    if (kind == K_BRKPT) slot_bad = (slot_of(idx) >= BP_LIM);
    if (kind == K_WATCH) slot_bad = (slot_of(idx) >= WP_LIM);
  end

  always_comb begin
    rd_take  = 1'b0;
    rd_clear = 1'b0;
    rd_fault = 1'b0;
    if (rd_en) begin
      case (kind)
        K_STATUS, K_EBASE, K_DBASE, K_CYCLES, K_CONFIG: rd_take = 1'b1;
        K_NONE: begin
          rd_clear = 1'b1;
          rd_fault = 1'b1;
        end
        default: rd_fault = 1'b1;
      endcase
    end
  end

  always_comb begin
    wr_fault = 1'b0;
    if (wr_en) begin
      case (kind)
        K_CYCLES, K_CONFIG, K_NONE: wr_fault = 1'b1;
        K_BRKPT, K_WATCH:           wr_fault = slot_bad;
        default:                    wr_fault = 1'b0;
      endcase
    end
  end

  assign wr_status = wr_en && (kind == K_STATUS);
  assign wr_ebase  = wr_en && (kind == K_EBASE);
  assign wr_dbase  = wr_en && (kind == K_DBASE);
  assign fault     = rd_fault | wr_fault;

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import csr_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_entry,
  input  logic       brk_entry,
  input  logic       exc_return,
  input  logic       brk_return,
  input  logic       wr_status,
  input  logic [2:0] wbits,
  output ena_t       ena_q
);

  ena_t ena_d;

  assign ena_d = next_enable(ena_q, exc_entry, brk_entry, exc_return,
                             brk_return, wr_status, wbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= '0;
    else        ena_q <= ena_d;
  end

endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= INIT;
    else        count_q <= count_q + W'(1);
  end

endmodule

// File: rtl/ctrl_csr_unit.sv
module ctrl_csr_unit
  import csr_unit_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                NUM_BP   = 4,
  parameter int                NUM_WP   = 4,
  parameter logic [DATA_W-1:0] CYC_INIT = '0,
  parameter logic [DATA_W-1:0] EBA_RST  = '0,
  parameter logic [DATA_W-1:0] DEBA_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [4:0]        csr_idx,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic              exc_entry,
  input  logic              brk_entry,
  input  logic              exc_return,
  input  logic              brk_return,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_en,
  output logic              access_fault
);

  localparam logic [DATA_W-1:0] CFG_WORD =
    {{(DATA_W-8){1'b0}}, 4'(NUM_WP), 4'(NUM_BP)};

  csr_kind_e         kind;
  logic              rd_take;
  logic              rd_clear;
  logic              wr_status;
  logic              wr_ebase;
  logic              wr_dbase;
  logic              fault_d;
  ena_t              ena_q;
  logic              ie_q;
  logic              eie_q;
  logic              bie_q;
  logic [DATA_W-1:0] cycles_q;
  logic [DATA_W-1:0] ebase_q;
  logic [DATA_W-1:0] dbase_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;
  logic              fault_q;

  csr_access_decode #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_dec (
    .rd_en     (csr_rd),
    .wr_en     (csr_wr),
    .idx       (csr_idx),
    .kind      (kind),
    .rd_take   (rd_take),
    .rd_clear  (rd_clear),
    .wr_status (wr_status),
    .wr_ebase  (wr_ebase),
    .wr_dbase  (wr_dbase),
    .fault     (fault_d)
  );

  irq_enable_reg u_ena (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_entry  (exc_entry),
    .brk_entry  (brk_entry),
    .exc_return (exc_return),
    .brk_return (brk_return),
    .wr_status  (wr_status),
    .wbits      (csr_wdata[2:0]),
    .ena_q      (ena_q)
  );

  cycle_counter #(.W(DATA_W), .INIT(CYC_INIT)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_q (cycles_q)
  );

  assign ie_q  = ena_q.ie;
  assign eie_q = ena_q.eie;
  assign bie_q = ena_q.bie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ebase_q <= EBA_RST;
      dbase_q <= DEBA_RST;
    end else begin
      if (wr_ebase) ebase_q <= csr_wdata;
      if (wr_dbase) dbase_q <= csr_wdata;
    end
  end

  always_comb begin
    case (kind)
      K_STATUS: rd_mux = {{(DATA_W-3){1'b0}}, ena_q};
      K_EBASE:  rd_mux = ebase_q;
      K_DBASE:  rd_mux = dbase_q;
      K_CYCLES: rd_mux = cycles_q;
      K_CONFIG: rd_mux = CFG_WORD;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
      if (rd_take)       rd_q <= rd_mux;
      else if (rd_clear) rd_q <= '0;
    end
  end

  assign rd_data      = rd_q;
  assign access_fault = fault_q;
  assign irq_en       = ie_q;

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk
  import csr_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_rd,
  input logic              csr_wr,
  input logic [4:0]        csr_idx,
  input logic              exc_entry,
  input logic              brk_entry,
  input logic              exc_return,
  input logic              brk_return,
  input logic [DATA_W-1:0] rd_data,
  input logic              access_fault,
  input logic              irq_en,
  input logic              ie_q,
  input logic              eie_q,
  input logic              bie_q,
  input logic [DATA_W-1:0] cycles_q
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r3_exc_entry: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (!irq_en && eie_q == $past(ie_q)));

  a_r4_brk_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_entry && !exc_entry) |=> (!irq_en && bie_q == $past(ie_q)));

  a_r5_exc_return: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry && !brk_entry) |=> (irq_en == $past(eie_q)));

  a_r6_brk_return: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_return && !exc_return && !exc_entry && !brk_entry)
      |=> (irq_en == $past(bie_q)));

  a_r9_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (cycles_q == $past(cycles_q) + DATA_W'(1)));

  a_r10_config_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_idx == IX_CONFIG) |=> access_fault);

  a_r13_unknown_read: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && kind_of(csr_idx) == K_NONE) |=> (access_fault && rd_data == '0));

  a_r14_quiet_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rd && !csr_wr) |=> !access_fault);

endmodule

bind ctrl_csr_unit csr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_rd       (csr_rd),
  .csr_wr       (csr_wr),
  .csr_idx      (csr_idx),
  .exc_entry    (exc_entry),
  .brk_entry    (brk_entry),
  .exc_return   (exc_return),
  .brk_return   (brk_return),
  .rd_data      (rd_data),
  .access_fault (access_fault),
  .irq_en       (irq_en),
  .ie_q         (ie_q),
  .eie_q        (eie_q),
  .bie_q        (bie_q),
  .cycles_q     (cycles_q)
);

// File: tb/ctrl_csr_unit_tb_top.sv
module ctrl_csr_unit_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          NBP        = 3;
  localparam int          NWP        = 2;
  localparam logic [31:0] C_INIT     = 32'hFFFF_FFF0;
  localparam logic [31:0] E_RST      = 32'h0000_0100;
  localparam logic [31:0] D_RST      = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [4:0]  csr_idx = '0;
  logic [31:0] csr_wdata = '0;
  logic        exc_entry = 1'b0, brk_entry = 1'b0;
  logic        exc_return = 1'b0, brk_return = 1'b0;
  logic [31:0] rd_data;
  logic        irq_en, access_fault;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  ctrl_csr_unit #(.DATA_W(32), .NUM_BP(NBP), .NUM_WP(NWP), .CYC_INIT(C_INIT),
                  .EBA_RST(E_RST), .DEBA_RST(D_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .exc_entry(exc_entry),
    .brk_entry(brk_entry), .exc_return(exc_return), .brk_return(brk_return),
    .rd_data(rd_data), .irq_en(irq_en), .access_fault(access_fault));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit          m_ie = 0, m_eie = 0, m_bie = 0;
  logic [31:0] m_eba = E_RST, m_deba = D_RST, m_cyc = C_INIT;
  logic [31:0] m_rd = '0;
  bit          m_fault = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_eie = 0; m_bie = 0;
      m_eba = E_RST; m_deba = D_RST; m_cyc = C_INIT;
      m_rd = '0; m_fault = 0;
    end else begin
      int ix;
      bit f;
      bit oie, oeie, obie;
      ix = int'(csr_idx);
      f = 0;
      oie = m_ie; oeie = m_eie; obie = m_bie;
      if (csr_rd) begin
        if (ix == 0)      m_rd = {29'd0, obie, oeie, oie};
        else if (ix == 1) m_rd = m_eba;
        else if (ix == 2) m_rd = m_deba;
        else if (ix == 3) m_rd = m_cyc;
        else if (ix == 4) m_rd = 32'(NWP * 16 + NBP);
        else if (ix == 5 || ix == 6 || (ix >= 8 && ix <= 15)) f = 1;
        else begin m_rd = '0; f = 1; end
      end
      if (csr_wr) begin
        if (ix == 1) m_eba = csr_wdata;
        else if (ix == 2) m_deba = csr_wdata;
        else if (ix == 3 || ix == 4) f = 1;
        else if (ix >= 8 && ix <= 11) begin if (ix - 8 >= NBP) f = 1; end
        else if (ix >= 12 && ix <= 15) begin if (ix - 12 >= NWP) f = 1; end
        else if (ix == 7 || ix >= 16) f = 1;
      end
      if (exc_entry) begin m_eie = oie; m_ie = 0; end
      else if (brk_entry) begin m_bie = oie; m_ie = 0; end
      else if (exc_return) m_ie = oeie;
      else if (brk_return) m_ie = obie;
      else if (csr_wr && ix == 0) begin
        m_ie = csr_wdata[0]; m_eie = csr_wdata[1]; m_bie = csr_wdata[2];
      end
      m_fault = f;
      m_cyc = m_cyc + 32'd1;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rd_data !== m_rd) begin
      failures++;
      $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, m_rd);
    end
    checks++;
    if (access_fault !== m_fault) begin
      failures++;
      $display("FAIL %s access_fault actual=%0b expected=%0b", cur_req, access_fault, m_fault);
    end
    checks++;
    if (irq_en !== m_ie) begin
      failures++;
      $display("FAIL %s irq_en actual=%0b expected=%0b", cur_req, irq_en, m_ie);
    end
  end

  task automatic drive(input bit rd, input bit wr, input int idx,
                       input logic [31:0] wd, input bit e, input bit b,
                       input bit er, input bit br);
    csr_rd = rd; csr_wr = wr; csr_idx = 5'(idx); csr_wdata = wd;
    exc_entry = e; brk_entry = b; exc_return = er; brk_return = br;
    @(negedge clk);
  endtask

  task automatic rd(input int idx);
    drive(1, 0, idx, '0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int idx, input logic [31:0] wd);
    drive(0, 1, idx, wd, 0, 0, 0, 0);
  endtask

  task automatic idle();
    drive(0, 0, 0, '0, 0, 0, 0, 0);
  endtask

  // explicit point check on a port value
  task automatic expect_val(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    expect_val("R1", "rd_data in reset", rd_data, 32'd0);
    expect_val("R1", "irq_en in reset", {31'd0, irq_en}, 32'd0);
    rst_n = 1'b1;

    cur_req = "R9";                    // counter read across the wrap point
    for (int i = 0; i < 24; i++) rd(3);
    idle();

    cur_req = "R1";
    rd(1); expect_val("R1", "ebase reset", rd_data, E_RST);
    rd(2); expect_val("R1", "dbase reset", rd_data, D_RST);
    rd(0); expect_val("R1", "status reset", rd_data, 32'd0);

    cur_req = "R2";
    wr(0, 32'hFFFF_FFF5); expect_val("R2", "irq_en after write", {31'd0, irq_en}, 32'd1);
    rd(0); expect_val("R2", "status readback", rd_data, 32'h5);
    wr(0, 32'h2); rd(0); expect_val("R2", "status readback 2", rd_data, 32'h2);

    cur_req = "R8";
    wr(1, 32'hDEAD_0040); wr(2, 32'h0BAD_F00C);
    drive(1, 1, 1, 32'h1234_5678, 0, 0, 0, 0);
    expect_val("R8", "read-before-write", rd_data, 32'hDEAD_0040);
    rd(1); expect_val("R8", "ebase", rd_data, 32'h1234_5678);
    rd(2); expect_val("R8", "dbase", rd_data, 32'h0BAD_F00C);

    cur_req = "R3";
    wr(0, 32'h1); drive(0, 0, 0, '0, 1, 0, 0, 0);
    rd(0); expect_val("R3", "status after exc entry", rd_data, 32'h2);
    cur_req = "R5";
    drive(0, 0, 0, '0, 0, 0, 1, 0);
    expect_val("R5", "irq_en after eret", {31'd0, irq_en}, 32'd1);
    cur_req = "R4";
    drive(0, 0, 0, '0, 0, 1, 0, 0);
    rd(0); expect_val("R4", "status after brk entry", rd_data, 32'h6);
    cur_req = "R6";
    drive(0, 0, 0, '0, 0, 0, 0, 1);
    expect_val("R6", "irq_en after bret", {31'd0, irq_en}, 32'd1);
    wr(0, 32'h1); drive(0, 0, 0, '0, 0, 0, 0, 1);
    expect_val("R6", "bret with saved 0", {31'd0, irq_en}, 32'd0);

    cur_req = "R7";
    wr(0, 32'h1);
    drive(0, 1, 0, 32'h0, 1, 1, 1, 1);
    rd(0); expect_val("R7", "exc wins", rd_data, 32'h2);
    wr(0, 32'h5);
    drive(0, 1, 0, 32'h7, 0, 1, 1, 0);
    rd(0); expect_val("R7", "brk over eret", rd_data, 32'h4);
    drive(0, 1, 0, 32'h0, 0, 0, 1, 1);
    rd(0); expect_val("R7", "eret over bret/write", rd_data, 32'h4);
    drive(0, 1, 0, 32'h3, 0, 0, 0, 1);
    rd(0); expect_val("R7", "bret over write", rd_data, 32'h5);

    cur_req = "R10";
    rd(4); expect_val("R10", "config word", rd_data, 32'h23);
    wr(4, 32'hFFFF_FFFF); expect_val("R10", "fault on config write", {31'd0, access_fault}, 32'd1);
    wr(3, 32'h0); expect_val("R10", "fault on counter write", {31'd0, access_fault}, 32'd1);
    rd(4); expect_val("R10", "config unchanged", rd_data, 32'h23);
    rd(3);

    cur_req = "R11";
    wr(1, 32'hCAFE_0001); rd(1);
    for (int ix = 5; ix <= 15; ix++) begin
      if (ix != 7) begin
        rd(ix);
        expect_val("R11", "fault on write-only read", {31'd0, access_fault}, 32'd1);
        expect_val("R11", "rd_data held", rd_data, 32'hCAFE_0001);
      end
    end
    wr(5, 32'h1); expect_val("R11", "cache write ok", {31'd0, access_fault}, 32'd0);
    wr(6, 32'h1); expect_val("R11", "cache write ok", {31'd0, access_fault}, 32'd0);

    cur_req = "R12";
    for (int ix = 8; ix <= 15; ix++) begin
      wr(ix, 32'h100);
      expect_val("R12", "slot write fault",
                 {31'd0, access_fault},
                 (ix < 12) ? ((ix - 8 >= NBP) ? 32'd1 : 32'd0)
                           : ((ix - 12 >= NWP) ? 32'd1 : 32'd0));
    end

    cur_req = "R13";
    rd(1);
    rd(7); expect_val("R13", "unknown read zero", rd_data, 32'd0);
    rd(1); rd(20); expect_val("R13", "unknown read zero", rd_data, 32'd0);
    rd(1); rd(31); expect_val("R13", "unknown read zero", rd_data, 32'd0);
    wr(16, 32'h7); expect_val("R13", "unknown write fault", {31'd0, access_fault}, 32'd1);
    rd(0);

    cur_req = "R14";
    rd(7); idle();
    expect_val("R14", "fault lasts one cycle", {31'd0, access_fault}, 32'd0);
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 100);
      drive(r < 40, (r % 3) == 0, int'($urandom % 32), $urandom,
            ($urandom % 9) == 0, ($urandom % 9) == 0,
            ($urandom % 7) == 0, ($urandom % 7) == 0);
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule